// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers twenty-four interrupt requests and presents the most urgent of them to a processor. Four of the requests arrive on external pins. The other twenty come from on-chip logic as active-high levels. Software gives each source an enable bit, a 3-bit priority and a routing bit. The routing bit sends the source to either the normal request output or the fast request output.

The handler reads a vector register to learn which source won. That read also records the winner's priority as in service. From then on, sources at or below that priority are held off, and only more urgent sources can interrupt the handler, so handlers nest. An end-of-service write retires the most recent level and restores the previous threshold.

Each external pin can be set to sense a level or an edge, and to be active-high or active-low. An edge leaves a sticky pending bit, and only an acknowledge write clears it.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Sources 0 to 3 come from `extPin[3:0]` and sources 4 to 23 from `srcIn[19:0]`. Internal sources are active-high levels. A read of address 3 returns the raw pending vector, one bit per source, whatever the enable bits hold.
- R2: A source whose bit in the enable register (address 0, bit n for source n) is zero never causes `irqOut` or `fiqOut`, and a vector read cannot return it.
- R3: The routing register (address 1) sends an eligible source to `fiqOut` when its bit is 1 and to `irqOut` when its bit is 0. Both outputs are registered.
- R4: Priorities sit in 4-bit slots, eight per word, starting at address 8 (source n at word 8+n/8, bits [(n%8)*4+2 : (n%8)*4]). A larger value is more urgent. A read of address 4 returns bit 31 set and bits [4:0] holding the index of the winning eligible source. When no source is eligible the read returns zero.
- R5: When eligible sources share the highest priority, the lowest index wins.
- R6: A vector read that returns a source marks that source's priority as in service. While that level is active, every source whose priority is at or below it is masked.
- R7: A write to address 6 retires the most recent in-service level and restores the threshold below it. Such a write with nothing in service has no effect.
- R8: Bits [19:16] of the external configuration register (address 2) invert pins 0 to 3, so a 1 makes that pin active-low.
- R9: Bits [3:0] of address 2 put pins 0 to 3 in edge mode. An edge sets a sticky pending bit. That bit clears only when the source index is written to address 5. Such a write to a level-mode source has no effect.
- R10: After reset every configuration register holds zero, no level is in service, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 20 | Internal request levels for sources 4..23 |
| extPin | input | 4 | External request pins for sources 0..3 |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered, updated on each read |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check four behaviours of the nesting logic: any winner is strictly more urgent than the active threshold, a vector read moves the threshold to the winner's level, an end-of-service write drops exactly one level or leaves an empty set empty, and a read with no winner yields zero. The bench's scenarios cover the rest. These are the routing and enable sweep across every internal source, the tie-breaking under many request patterns, and a three-deep nesting sequence. The pin tests also need the bench, because they depend on synchronizer delay: polarity inversion, edge stickiness and acknowledge.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int PRIO_SLOT = 4;
  localparam int EXT_INV_LSB = 16;

  localparam logic [ADDR_W-1:0] A_ENABLE = 4'd0;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_EXTCFG = 4'd2;
  localparam logic [ADDR_W-1:0] A_PEND   = 4'd3;
  localparam logic [ADDR_W-1:0] A_VEC    = 4'd4;
  localparam logic [ADDR_W-1:0] A_ACK    = 4'd5;
  localparam logic [ADDR_W-1:0] A_EOS    = 4'd6;
  localparam int A_PRIO0 = 8;

  typedef struct packed {
    logic cfgWr;
    logic ackStb;
    logic eosStb;
    logic vecRd;
  } ctl_stb_t;
endpackage

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl
  import nest_irq_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWr,
  input  logic                      busRd,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      winValid,
  input  logic [PRIO_W-1:0]         winPrio,
  output ctl_stb_t                  stb,
  output logic [(1<<PRIO_W)-1:0]    activeLvl,
  output logic                      activeAny,
  output logic [PRIO_W-1:0]         activeTop
);
  localparam int NUM_LVL = 1 << PRIO_W;

  // Decode bus cycles into strobes for the datapath.
  always_comb begin
    stb.cfgWr  = busWr && (busAddr == A_ENABLE || busAddr == A_ROUTE ||
                           busAddr == A_EXTCFG || int'(busAddr) >= A_PRIO0);
    stb.ackStb = busWr && (busAddr == A_ACK);
    stb.eosStb = busWr && (busAddr == A_EOS);
    stb.vecRd  = busRd && (busAddr == A_VEC);
  end

  // Levels in service only ever grow upward, so the set of active levels
  // doubles as the nesting stack: its highest bit is the top entry.
  always_comb begin
    activeAny = |activeLvl;
    activeTop = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (activeLvl[l]) activeTop = PRIO_W'(l);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeLvl <= '0;
    end else if (stb.vecRd && winValid) begin
      activeLvl[winPrio] <= 1'b1;
    end else if (stb.eosStb && activeAny) begin
      activeLvl[activeTop] <= 1'b0;
    end
  end
endmodule

// File: rtl/nest_irq_dp.sv
module nest_irq_dp
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_EXT = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_stb_t                   stb,
  input  logic                       busRd,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic [NUM_SRC-NUM_EXT-1:0] srcIn,
  input  logic [NUM_EXT-1:0]         extPin,
  input  logic                       activeAny,
  input  logic [PRIO_W-1:0]          activeTop,
  output logic                       winValid,
  output logic [PRIO_W-1:0]          winPrio,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       irqOut,
  output logic                       fiqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int SLOTS = DATA_W / PRIO_SLOT;

  logic [NUM_SRC-1:0] enableR, routeR, eligible;
  logic [NUM_EXT-1:0] edgeModeR, invertR;
  logic [PRIO_W-1:0]  prioR [NUM_SRC];
  logic [IDX_W-1:0]   winIdx;
  logic [DATA_W-1:0]  prioWord;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata;

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR   <= '0;
      routeR    <= '0;
      edgeModeR <= '0;
      invertR   <= '0;
      for (int i = 0; i < NUM_SRC; i++) prioR[i] <= '0;
    end else if (stb.cfgWr) begin
      if (busAddr == A_ENABLE) enableR <= busWdata[NUM_SRC-1:0];
      if (busAddr == A_ROUTE)  routeR  <= busWdata[NUM_SRC-1:0];
      if (busAddr == A_EXTCFG) begin
        edgeModeR <= busWdata[NUM_EXT-1:0];
        invertR   <= busWdata[EXT_INV_LSB +: NUM_EXT];
      end
      for (int i = 0; i < NUM_SRC; i++)
        if (busAddr == ADDR_W'(A_PRIO0 + i / SLOTS))
          prioR[i] <= busWdata[(i % SLOTS) * PRIO_SLOT +: PRIO_W];
    end
  end

  // External pins: two-flop synchronizer, a third flop for edge history.
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic [2:0] syncQ;
    logic       sticky, nowOn, wasOn;

    assign nowOn = syncQ[1] ^ invertR[e];
    assign wasOn = syncQ[2] ^ invertR[e];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '0;
        sticky <= 1'b0;
      end else begin
        syncQ <= {syncQ[1:0], extPin[e]};
        if (edgeModeR[e] && nowOn && !wasOn)
          sticky <= 1'b1;
        else if (stb.ackStb && busWdata[IDX_W-1:0] == IDX_W'(e))
          sticky <= 1'b0;
      end
    end

    assign pendVec[e] = edgeModeR[e] ? sticky : nowOn;
  end

  assign pendVec[NUM_SRC-1:NUM_EXT] = srcIn;

  // Linear priority scan: strict compare keeps the lower index on ties.
  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      eligible[i] = enableR[i] && pendVec[i] &&
                    (!activeAny || prioR[i] > activeTop);
      if (eligible[i] && (!winValid || prioR[i] > winPrio)) begin
        winValid = 1'b1;
        winPrio  = prioR[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |(eligible & ~routeR);
      fiqOut <= |(eligible & routeR);
    end
  end

  // Readback.
  always_comb begin
    prioWord = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (busAddr == ADDR_W'(A_PRIO0 + i / SLOTS))
        prioWord[(i % SLOTS) * PRIO_SLOT +: PRIO_W] = prioR[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRd) begin
      if (busAddr == A_ENABLE)      busRdata <= DATA_W'(enableR);
      else if (busAddr == A_ROUTE)  busRdata <= DATA_W'(routeR);
      else if (busAddr == A_EXTCFG) busRdata <= DATA_W'(edgeModeR) |
                                               (DATA_W'(invertR) << EXT_INV_LSB);
      else if (busAddr == A_PEND)   busRdata <= DATA_W'(pendVec);
      else if (busAddr == A_VEC)    busRdata <= {winValid, {(DATA_W-1-IDX_W){1'b0}}, winIdx};
      else if (int'(busAddr) >= A_PRIO0) busRdata <= prioWord;
      else busRdata <= '0;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_EXT = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-NUM_EXT-1:0] srcIn,
  input  logic [NUM_EXT-1:0]         extPin,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       irqOut,
  output logic                       fiqOut
);
  ctl_stb_t                  stb;
  logic                      winValid, activeAny;
  logic [PRIO_W-1:0]         winPrio, activeTop;
  logic [(1<<PRIO_W)-1:0]    activeLvl;
  logic [NUM_SRC-1:0]        pendVec;

  nest_irq_ctl #(.PRIO_W(PRIO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .winValid(winValid), .winPrio(winPrio), .stb(stb),
    .activeLvl(activeLvl), .activeAny(activeAny), .activeTop(activeTop)
  );

  nest_irq_dp #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .srcIn(srcIn), .extPin(extPin),
    .activeAny(activeAny), .activeTop(activeTop),
    .winValid(winValid), .winPrio(winPrio), .pendVec(pendVec),
    .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int PRIO_W  = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input ctl_stb_t                stb,
  input logic                    winValid,
  input logic [PRIO_W-1:0]       winPrio,
  input logic [(1<<PRIO_W)-1:0]  activeLvl,
  input logic                    activeAny,
  input logic [PRIO_W-1:0]       activeTop,
  input logic [NUM_SRC-1:0]      pendVec,
  input logic [DATA_W-1:0]       busRdata,
  input logic                    irqOut,
  input logic                    fiqOut
);
  // R6
  mask_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && activeAny) |-> (winPrio > activeTop));

  // R6
  push_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecRd && winValid) |=> (activeAny && activeTop == $past(winPrio)));

  // R7
  pop_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eosStb && activeAny) |=> ($countones(activeLvl) + 1 == $countones($past(activeLvl))));

  // R7
  empty_eos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eosStb && !activeAny) |=> !activeAny);

  // R4
  no_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecRd && !winValid) |=> (busRdata == '0));

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |=> (!irqOut && !fiqOut));
endmodule

bind nest_irq_ctrl nest_irq_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .winValid(winValid), .winPrio(winPrio),
  .activeLvl(activeLvl), .activeAny(activeAny), .activeTop(activeTop),
  .pendVec(pendVec), .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
);

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] srcIn = '0;
  logic [3:0]  extPin = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int total = 0, fails = 0;
  bit done = 0;
  int prioSh [24];

  always #2 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .extPin(extPin),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1; busAddr = a;
    @(negedge clk); busRd = 0; d = busRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic loadPrio();
    for (int w = 0; w < 3; w++) begin
      logic [31:0] word = '0;
      for (int s = 0; s < 8; s++) word[s*4 +: 3] = 3'(prioSh[w*8+s]);
      wr(4'(8 + w), word);
    end
  endtask

  function automatic logic [31:0] expWin(input logic [23:0] pend);
    int best = -1;
    for (int i = 0; i < 24; i++)
      if (pend[i] && (best < 0 || prioSh[i] > prioSh[best])) best = i;
    return (best < 0) ? 32'h0 : (32'h8000_0000 | 32'(best));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq", 32'(irqOut), 0);
    check("R10 fiq", 32'(fiqOut), 0);
    rd(4'd0, d); check("R10 enable", d, 0);
    rd(4'd2, d); check("R10 extcfg", d, 0);
    rd(4'd4, d); check("R4 empty vector", d, 0);

    // R1 R3 R4: sweep every internal source alone, odd ones fast
    for (int i = 0; i < 24; i++) prioSh[i] = 0;
    wr(4'd0, 32'h00FF_FFFF);
    wr(4'd1, 32'h00AA_AAAA);
    for (int i = 4; i < 24; i++) begin
      srcIn = 20'(1 << (i - 4));
      settle();
      check("R3 fiq route", 32'(fiqOut), 32'(i % 2));
      check("R3 irq route", 32'(irqOut), 32'(1 - i % 2));
      rd(4'd3, d); check("R1 pending", d, 32'(1) << i);
      rd(4'd4, d); check("R4 vector", d, 32'h8000_0000 | 32'(i));
      wr(4'd6, 0);
    end

    // R2 disabled sources
    wr(4'd0, 0);
    srcIn = '1;
    settle();
    check("R2 irq", 32'(irqOut), 0);
    check("R2 fiq", 32'(fiqOut), 0);
    rd(4'd3, d); check("R2 raw pending", d, 32'h00FF_FFF0);
    rd(4'd4, d); check("R2 vector", d, 0);

    // R4 R5 priority patterns
    wr(4'd0, 32'h00FF_FFFF);
    wr(4'd1, 0);
    for (int i = 4; i < 24; i++) prioSh[i] = (i * 5 + 3) % 8;
    loadPrio();
    rd(4'd9, d); check("R4 prio word", d[11:0], {1'b0, 3'(prioSh[10]), 1'b0, 3'(prioSh[9]), 1'b0, 3'(prioSh[8])});
    for (int k = 0; k < 24; k++) begin
      logic [31:0] m = ((32'(k) + 1) * 32'h9E37_79B1) >> 7;
      logic [31:0] e;
      srcIn = m[19:0];
      settle();
      e = expWin({m[19:0], 4'b0});
      check("R3 irq level", 32'(irqOut), 32'(e[31]));
      rd(4'd4, d); check("R4 R5 winner", d, e);
      if (e[31]) wr(4'd6, 0);
    end

    // R5 tie
    for (int i = 0; i < 24; i++) prioSh[i] = 4;
    loadPrio();
    srcIn = 20'(1 << (15 - 4)) | 20'(1 << (7 - 4));
    settle();
    rd(4'd4, d); check("R5 tie lower index", d, 32'h8000_0007);
    wr(4'd6, 0);

    // R6 R7 nesting
    srcIn = '0;
    prioSh[10] = 2; prioSh[12] = 5; prioSh[8] = 3;
    loadPrio();
    srcIn = 20'(1 << (10 - 4));
    settle();
    check("R6 first request", 32'(irqOut), 1);
    rd(4'd4, d); check("R6 vector 10", d, 32'h8000_000A);
    settle();
    check("R6 self masked", 32'(irqOut), 0);
    srcIn = srcIn | 20'(1 << (12 - 4));
    settle();
    check("R6 higher preempts", 32'(irqOut), 1);
    rd(4'd4, d); check("R6 vector 12", d, 32'h8000_000C);
    srcIn = srcIn | 20'(1 << (8 - 4));
    settle();
    check("R6 lower masked", 32'(irqOut), 0);
    rd(4'd4, d); check("R6 masked vector", d, 0);
    srcIn = srcIn & ~20'(1 << (12 - 4));
    wr(4'd6, 0);
    settle();
    check("R7 threshold restored", 32'(irqOut), 1);
    rd(4'd4, d); check("R7 vector 8", d, 32'h8000_0008);
    wr(4'd6, 0); wr(4'd6, 0); wr(4'd6, 0);
    settle();
    rd(4'd4, d); check("R7 empty pop harmless", d, 32'h8000_0008);
    wr(4'd6, 0);
    srcIn = '0;

    // R8 polarity, R9 edge mode
    for (int i = 0; i < 24; i++) prioSh[i] = 0;
    prioSh[2] = 6;
    loadPrio();
    wr(4'd2, 32'h0002_0004);
    extPin = 4'b0001;
    settle();
    rd(4'd3, d); check("R8 active-high and active-low pins", d[3:0], 4'b0011);
    extPin = 4'b0011;
    settle();
    rd(4'd3, d); check("R8 inverted pin released", d[3:0], 4'b0001);
    extPin = 4'b0111;
    repeat (3) @(negedge clk);
    extPin = 4'b0011;
    settle();
    rd(4'd3, d); check("R9 sticky edge", d[3:0], 4'b0101);
    rd(4'd4, d); check("R9 edge source wins", d, 32'h8000_0002);
    wr(4'd6, 0);
    wr(4'd5, 0);
    settle();
    rd(4'd3, d); check("R9 ack on level source", d[3:0], 4'b0101);
    wr(4'd5, 2);
    settle();
    rd(4'd3, d); check("R9 ack clears edge", d[3:0], 4'b0001);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule